// File: doc/BRIEF.md
# PLL Lock Qualification Controller

This controller decides when a freshly enabled PLL may drive the system clock. It runs on the reference clock. A lock indicator is not accepted on a single sample. After a start request the controller turns the PLL on and keeps the clock select low. It then waits until the synchronized lock indicator has stayed high for a programmable number of consecutive phase-detector periods. Only then does it raise the clock select.

Time is counted in phase-detector periods. One period is the reference divisor times the reference clock period. An internal tick marks the end of each period. An overall timeout starts when the PLL is enabled and keeps running when lock drops. If the timeout expires before qualification succeeds, the controller gives up, reports a failure and never selects the PLL. The PLL itself, the glitch-free clock switch and the loop filter are outside this block.

Top module: `pll_lock_qual`

## Requirements
- R1: While enabling or qualifying, a tick occurs once every `ref_div` reference cycles. A `ref_div` of 0 behaves exactly like 1. The first tick comes `ref_div` cycles after the start request is accepted.
- R2: After reset all outputs are 0. A `start` sampled high in the idle state sets `pll_en` to 1 one cycle later, while `clk_sel`, `done` and `fail` stay 0.
- R3: If `TMO_TICKS` ticks pass after the start without qualification completing, `fail` becomes 1 and `pll_en` becomes 0. The timeout is counted from the start and is never restarted by a lock drop. `clk_sel` is never 1 in the failed state.
- R4: `lock_raw` goes through a two-flop synchronizer. The controller leaves the waiting state only when the synchronized lock reads 1.
- R5: Qualification needs the synchronized lock to stay high for Q consecutive ticks counted while qualifying. Q is `qual_len` limited to the range 10 to 100: smaller values act as 10 and larger values act as 100.
- R6: If the synchronized lock reads 0 while qualifying, the qualify count clears and the controller returns to waiting for lock. The timeout keeps counting.
- R7: When qualification completes, `clk_sel` and `done` rise together and `pll_en` stays 1.
- R8: If the timeout and the qualification completion fall on the same tick, the controller fails.
- R9: A `start` that arrives while the controller is waiting or qualifying has no effect on the outcome or its timing.
- R10: The selected state holds `clk_sel` and ignores `start` until reset. A `start` in the failed state restarts the sequence with fresh counters.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to bring up the PLL |
| lock_raw | input | 1 | Asynchronous lock indicator from the PLL |
| ref_div | input | DIV_W | Reference divisor; sets the tick period |
| qual_len | input | QLEN_W | Qualification length in ticks, limited to 10..100 |
| pll_en | output | 1 | PLL enable |
| clk_sel | output | 1 | Select the PLL as the system clock |
| done | output | 1 | Qualification succeeded |
| fail | output | 1 | Lock was not qualified before the timeout |

## Verification
The assertions check the following on every cycle:
- failure and clock select are never high together;
- the select rises only while the PLL is enabled and the synchronized lock is high;
- a lock drop during qualification always leads back to waiting or to failure;
- the timeout count never decreases within one attempt;
- the selected state is held.

Only the bench scenarios can show the exact cycle on which the select or the failure appears. The bench sweeps divisors, clamped qualification lengths and lock patterns that include an early spurious lock pulse. It also covers the tie between timeout and completion, a start issued while busy, and the restart after a failure.

// File: rtl/pll_lock_qual.sv
`timescale 1ns/1ps
module pll_lock_qual #(
  parameter int DIV_W     = 8,
  parameter int QLEN_W    = 7,
  parameter int QUAL_MIN  = 10,
  parameter int QUAL_MAX  = 100,
  parameter int TMO_TICKS = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              lock_raw,
  input  logic [DIV_W-1:0]  ref_div,
  input  logic [QLEN_W-1:0] qual_len,
  output logic              pll_en,
  output logic              clk_sel,
  output logic              done,
  output logic              fail
);
  localparam int TMO_W = $clog2(TMO_TICKS + 1);
  localparam logic [QLEN_W-1:0] QMIN_V = QLEN_W'(QUAL_MIN);
  localparam logic [QLEN_W-1:0] QMAX_V = QLEN_W'(QUAL_MAX);
  localparam logic [TMO_W-1:0]  TMO_LAST = TMO_W'(TMO_TICKS - 1);

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_QUAL, S_SEL, S_FAIL} state_t;
  state_t state;

  logic              sync1, lock_s;
  logic [DIV_W-1:0]  cnt;
  logic [TMO_W-1:0]  tmo;
  logic [QLEN_W-1:0] q;
  logic [DIV_W-1:0]  div_eff;
  logic [QLEN_W-1:0] qlen_eff;
  logic              busy, tick, tmo_hit, q_done;

  assign busy    = (state == S_WAIT) || (state == S_QUAL);
  assign div_eff = (ref_div == '0) ? DIV_W'(1) : ref_div;
  assign qlen_eff = (qual_len < QMIN_V) ? QMIN_V :
                    (qual_len > QMAX_V) ? QMAX_V : qual_len;
  assign tick    = busy && (cnt == div_eff - DIV_W'(1));
  assign tmo_hit = tick && (tmo == TMO_LAST);
  assign q_done  = tick && lock_s && (q == qlen_eff - QLEN_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1  <= 1'b0;
      lock_s <= 1'b0;
    end else begin
      sync1  <= lock_raw;
      lock_s <= sync1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !busy) cnt <= '0;
    else if (tick)    cnt <= '0;
    else              cnt <= cnt + DIV_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst || !busy) tmo <= '0;
    else if (tick)    tmo <= tmo + TMO_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst || state != S_QUAL || !lock_s) q <= '0;
    else if (tick)                         q <= q + QLEN_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) state <= S_IDLE;
    else begin
      case (state)
        S_IDLE: if (start) state <= S_WAIT;
        S_WAIT: begin
          if (tmo_hit)     state <= S_FAIL;
          else if (lock_s) state <= S_QUAL;
        end
        S_QUAL: begin
          if (tmo_hit)      state <= S_FAIL;
          else if (!lock_s) state <= S_WAIT;
          else if (q_done)  state <= S_SEL;
        end
        S_SEL:  state <= S_SEL;
        S_FAIL: if (start) state <= S_WAIT;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign pll_en  = busy || (state == S_SEL);
  assign clk_sel = (state == S_SEL);
  assign done    = (state == S_SEL);
  assign fail    = (state == S_FAIL);

  p_fail_excl_sel_r3: assert property (@(posedge clk) disable iff (rst)
    !(fail && clk_sel));
  p_sel_needs_en_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(clk_sel) |-> $past(pll_en) && $past(lock_s));
  p_drop_leaves_qual_r6: assert property (@(posedge clk) disable iff (rst)
    (state == S_QUAL && !lock_s) |=> (state == S_WAIT || state == S_FAIL));
  p_tmo_monotone_r3: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> tmo >= $past(tmo));
  p_sel_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    clk_sel |=> clk_sel);
  p_wait_needs_lock_r4: assert property (@(posedge clk) disable iff (rst)
    (state == S_WAIT && !lock_s) |=> state != S_QUAL);
endmodule

// File: tb/test_pll_lock_qual.sv
`timescale 1ns/1ps
module test_pll_lock_qual;
  localparam int T = 20;
  logic clk = 1'b0, rst = 1'b1, start = 1'b0, lock_raw = 1'b0;
  logic [7:0] ref_div = 8'd1;
  logic [6:0] qual_len = 7'd10;
  logic pll_en, clk_sel, done, fail;
  int checks = 0, errors = 0;

  pll_lock_qual #(.TMO_TICKS(T)) i_pll_lock_qual (
    .clk(clk), .rst(rst), .start(start), .lock_raw(lock_raw),
    .ref_div(ref_div), .qual_len(qual_len),
    .pll_en(pll_en), .clk_sel(clk_sel), .done(done), .fail(fail));

  always #10 clk = ~clk;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int expect_edge(int d, int ql, int first, output bit efail);
    int de = (d == 0) ? 1 : d;
    int qe = (ql < 10) ? 10 : (ql > 100) ? 100 : ql;
    int m0 = (first + de - 1) / de;
    int sel = (m0 + qe - 1) * de;
    int to = T * de;
    efail = (sel >= to);
    return efail ? to : sel;
  endfunction

  task automatic do_reset(bit lk);
    @(negedge clk);
    rst = 1'b1; start = 1'b0; lock_raw = lk;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // mode 0: lock high before start; 1: spurious pulse then lock; 2: no lock
  task automatic run(int d, int ql, int mode, bit fresh);
    int n = 0, en;
    bit efail;
    int first = (mode == 0) ? 2 : (mode == 1) ? 13 : 1000000;
    string tag = (mode == 0) ? "R1 R3 R4 R5 R7 R8" : (mode == 1) ? "R6 R9 R4" : "R3";
    ref_div = d[7:0]; qual_len = ql[6:0];
    if (fresh) do_reset(mode == 0);
    en = expect_edge(d, ql, first, efail);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    while (n < 5000) begin
      @(posedge clk);
      @(negedge clk);
      n++;
      if (n == 1) chk(pll_en && !clk_sel && !done && !fail, "R2 enable", {pll_en, clk_sel, fail}, 4);
      if (clk_sel || fail) break;
      start = (n == 3);
      if (mode == 1) begin
        if (n == 2) lock_raw = 1'b1;
        if (n == 5) lock_raw = 1'b0;
        if (n == 9) lock_raw = 1'b1;
      end
    end
    start = 1'b0;
    chk(n == en && fail == efail && clk_sel == !efail && done == !efail
        && pll_en == !efail, tag, n * 2 + int'(fail), en * 2 + int'(efail));
  endtask

  initial begin
    #(20ns * 200000);
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int qs[7] = '{0, 9, 10, 15, 19, 20, 120};
    do_reset(1'b0);
    chk(!pll_en && !clk_sel && !done && !fail, "R2 reset", {pll_en, clk_sel, done, fail}, 0);
    for (int d = 0; d <= 4; d++)
      for (int k = 0; k < 7; k++)
        for (int m = 0; m < 3; m++)
          run(d, qs[k], m, 1'b1);

    run(2, 10, 0, 1'b1);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (4) @(negedge clk);
    chk(clk_sel && done && pll_en, "R10 select held", clk_sel, 1);

    run(1, 30, 2, 1'b1);
    lock_raw = 1'b1;
    repeat (3) @(negedge clk);
    chk(fail && !pll_en, "R3 failed", fail, 1);
    run(3, 12, 0, 1'b0);
    chk(clk_sel, "R10 restart", clk_sel, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule